// File: doc/BRIEF.md
# Interrupt Line Mapper with Global Status

This block gathers the interrupt conditions of a processing node onto four CPU interrupt lines. The sources are eight buffered data sources, each with an input and an output condition: six link channels (0 to 5) and two streaming ports (A and B). There are also one bus-status condition, two clock conditions and three external-line conditions. Each CPU line has its own 32-bit enable register. A line goes high when any condition enabled in its register is asserted, so one condition may drive several lines and several conditions may share one line.

A read-only global status word gathers, for every buffered source, whether data is waiting, whether space is free and whether its input or output condition is active. Interrupt service code uses it to find which source raised a shared line.

Any write that places a 1 in an enable bit produces a one-cycle re-arm pulse for that condition. This pulse restarts the burst-mode condition logic that sits outside the block.

Top module: `intmap_top`

## Requirements
- R1: After reset all four enable registers read 0x00000000, and every interrupt line and re-arm output is low.
- R2: Interrupt lines are registered and active high. Line n is high in the cycle after the rising edge at which some condition enabled in register n was asserted. It is low after an edge at which no enabled condition was asserted.
- R3: Enable bit layout: source k (0..5 = channel 0..5, 6 = port A, 7 = port B) owns bits 31-2k (output condition) and 30-2k (input condition). Bit 15 is the bus-status condition. Bits 14 and 13 are clock conditions 1 and 0. Bits 12, 11 and 10 are external lines 2, 1 and 0.
- R4: Several conditions may be enabled on one line, and one condition may be enabled on several lines; each line is the OR of its enabled conditions.
- R5: A write to an enable register drives rearm[i] high for exactly the next cycle whenever write-data bit 10+i is 1. This holds even when that enable bit was already set.
- R6: rearm is all zero in the cycle after any edge without an enable-register write. This includes a write of zero and a write to the status address.
- R7: Bits 9..0 of the enable registers ignore writes and read as zero.
- R8: The status word's bits 15..0 hold one pair per source k. Bit 15-2k is space available (not output full) and bit 14-2k is data available (not input empty). Both are sampled at each rising edge.
- R9: Status bits 31-2k and 30-2k show source k's output and input condition, sampled at each rising edge.
- R10: After reset the status word reads 0xAAAAAAAA, independent of the source inputs.
- R11: An enable write acts on its line one edge after the write edge. At the write edge itself the line is still computed from the old enable value.
- R12: Address map: 0..3 are the enable registers of lines 0..3, 4 is the status word, and 5..7 read zero. Writes to addresses 4..7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| src_in_cond | input | 8 | Input condition per buffered source |
| src_out_cond | input | 8 | Output condition per buffered source |
| src_in_empty | input | 8 | Input buffer empty per source |
| src_out_full | input | 8 | Output buffer full per source |
| bus_cond | input | 1 | Bus-status condition |
| tclk_cond | input | 2 | Clock conditions 1 and 0 |
| ext_cond | input | 3 | External-line conditions 2..0 |
| irq_line | output | 4 | CPU interrupt lines |
| rearm | output | 22 | Re-arm pulses, bit i for enable bit 10+i |

## Verification
Two functions can meet in one cycle: an enable write and an asserted condition on the same line. The bench holds a channel's output condition high so that its line is up. It then writes zero to that line's register. It expects the line to stay high for the sample right after the write edge and to drop one edge later. In the same cycle as that write, it checks that the re-arm pulse is absent, because the written word sets no bit. A rewrite of already-set bits is also checked to give a full re-arm pulse while the line stays steady.

// File: rtl/intmap_pkg.sv
package intmap_pkg;
  localparam int FIFO_SRCS = 8;
  localparam int TCLK_N    = 2;
  localparam int EXT_N     = 3;
  localparam int REG_W     = 32;
  localparam int RSV_W     = 10;
  localparam int COND_W    = 2 * FIFO_SRCS + 1 + TCLK_N + EXT_N;
  localparam int STAT_HALF = 2 * FIFO_SRCS;
  localparam int BUS_IDX   = EXT_N + TCLK_N;

  localparam logic [REG_W-1:0] EN_MASK  = {{COND_W{1'b1}}, {RSV_W{1'b0}}};
  localparam logic [REG_W-1:0] STAT_RST = {(REG_W/2){2'b10}};

  // Condition vector, index i matches enable bit RSV_W+i.
  function automatic logic [COND_W-1:0] pack_cond(
    input logic [FIFO_SRCS-1:0] in_c,
    input logic [FIFO_SRCS-1:0] out_c,
    input logic                 bus_c,
    input logic [TCLK_N-1:0]    tclk_c,
    input logic [EXT_N-1:0]     ext_c
  );
    logic [COND_W-1:0] v;
    v = '0;
    for (int k = 0; k < FIFO_SRCS; k++) begin
      v[COND_W-1-2*k] = out_c[k];
      v[COND_W-2-2*k] = in_c[k];
    end
    v[BUS_IDX] = bus_c;
    for (int j = 0; j < TCLK_N; j++) v[EXT_N+j] = tclk_c[j];
    for (int j = 0; j < EXT_N; j++)  v[j] = ext_c[j];
    return v;
  endfunction

  // Global status word.
  function automatic logic [REG_W-1:0] pack_status(
    input logic [FIFO_SRCS-1:0] in_empty,
    input logic [FIFO_SRCS-1:0] out_full,
    input logic [FIFO_SRCS-1:0] in_c,
    input logic [FIFO_SRCS-1:0] out_c
  );
    logic [REG_W-1:0] s;
    s = '0;
    for (int k = 0; k < FIFO_SRCS; k++) begin
      s[STAT_HALF-1-2*k]           = ~out_full[k];
      s[STAT_HALF-2-2*k]           = ~in_empty[k];
      s[STAT_HALF+STAT_HALF-1-2*k] = out_c[k];
      s[STAT_HALF+STAT_HALF-2-2*k] = in_c[k];
    end
    return s;
  endfunction

  // Any enabled condition asserted.
  function automatic logic any_enabled(
    input logic [REG_W-1:0]  en,
    input logic [COND_W-1:0] cond
  );
    return |(en & {cond, {RSV_W{1'b0}}});
  endfunction
endpackage

// File: rtl/intmap_regs.sv
module intmap_regs
  import intmap_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [REG_W-1:0]                  wdata,
  output logic [NUM_LINES-1:0][REG_W-1:0]   en_q,
  output logic [COND_W-1:0]                 rearm_q,
  output logic                              wr_hit
);
  logic [NUM_LINES-1:0] line_sel;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign line_sel[g] = wr && (addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           en_q[g] <= '0;
      else if (line_sel[g]) en_q[g] <= wdata & EN_MASK;
    end
  end

  assign wr_hit = |line_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rearm_q <= '0;
    else if (wr_hit) rearm_q <= wdata[REG_W-1:RSV_W];
    else             rearm_q <= '0;
  end
endmodule

// File: rtl/intmap_linegen.sv
module intmap_linegen
  import intmap_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LINES-1:0][REG_W-1:0] en_q,
  input  logic [COND_W-1:0]               cond,
  output logic [NUM_LINES-1:0]            irq_q
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_irq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[g] <= 1'b0;
      else        irq_q[g] <= any_enabled(en_q[g], cond);
    end
  end
endmodule

// File: rtl/intmap_status.sv
module intmap_status
  import intmap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FIFO_SRCS-1:0] in_empty,
  input  logic [FIFO_SRCS-1:0] out_full,
  input  logic [FIFO_SRCS-1:0] in_c,
  input  logic [FIFO_SRCS-1:0] out_c,
  output logic [REG_W-1:0]     status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= STAT_RST;
    else        status_q <= pack_status(in_empty, out_full, in_c, out_c);
  end
endmodule

// File: rtl/intmap_top.sv
module intmap_top
  import intmap_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [FIFO_SRCS-1:0] src_in_cond,
  input  logic [FIFO_SRCS-1:0] src_out_cond,
  input  logic [FIFO_SRCS-1:0] src_in_empty,
  input  logic [FIFO_SRCS-1:0] src_out_full,
  input  logic                 bus_cond,
  input  logic [TCLK_N-1:0]    tclk_cond,
  input  logic [EXT_N-1:0]     ext_cond,
  output logic [NUM_LINES-1:0] irq_line,
  output logic [COND_W-1:0]    rearm
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_LINES);

  logic [NUM_LINES-1:0][REG_W-1:0] en_q;
  logic [COND_W-1:0]               cond_vec;
  logic [REG_W-1:0]                status_q;
  logic                            wr_hit;

  assign cond_vec = pack_cond(src_in_cond, src_out_cond, bus_cond, tclk_cond, ext_cond);

  intmap_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .en_q    (en_q),
    .rearm_q (rearm),
    .wr_hit  (wr_hit)
  );

  intmap_linegen #(.NUM_LINES(NUM_LINES)) u_lines (
    .clk   (clk),
    .rst_n (rst_n),
    .en_q  (en_q),
    .cond  (cond_vec),
    .irq_q (irq_line)
  );

  intmap_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_empty (src_in_empty),
    .out_full (src_out_full),
    .in_c     (src_in_cond),
    .out_c    (src_out_cond),
    .status_q (status_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STAT_ADDR) reg_rdata = status_q;
    for (int i = 0; i < NUM_LINES; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = en_q[i];
  end
endmodule

// File: rtl/intmap_chk.sv
module intmap_chk
  import intmap_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [REG_W-1:0]     reg_wdata,
  input logic [REG_W-1:0]     reg_rdata,
  input logic [COND_W-1:0]    cond_vec,
  input logic [NUM_LINES-1:0] irq_line,
  input logic [COND_W-1:0]    rearm,
  input logic [FIFO_SRCS-1:0] src_in_empty,
  input logic [REG_W-1:0]     status_q,
  input logic                 wr_hit
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_LINES);

  // R5
  rearm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> rearm == $past(reg_wdata[REG_W-1:RSV_W]));

  // R6
  rearm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> rearm == '0);

  // R2
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_vec == '0) |=> (irq_line == '0));

  // R7
  rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != STAT_ADDR) |-> (reg_rdata[RSV_W-1:0] == '0));

  // R8
  stat_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> status_q[STAT_HALF-2] == !$past(src_in_empty[0]));
endmodule

bind intmap_top intmap_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .cond_vec     (cond_vec),
  .irq_line     (irq_line),
  .rearm        (rearm),
  .src_in_empty (src_in_empty),
  .status_q     (status_q),
  .wr_hit       (wr_hit)
);

// File: tb/intmap_top_bench.sv
`timescale 1ns/1ps
module intmap_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  src_in_cond = '0, src_out_cond = '0;
  logic [7:0]  src_in_empty = '1, src_out_full = '0;
  logic        bus_cond = 1'b0;
  logic [1:0]  tclk_cond = '0;
  logic [2:0]  ext_cond = '0;
  logic [3:0]  irq_line;
  logic [21:0] rearm;

  int n_chk = 0;
  int n_err = 0;
  logic [21:0] rearm_seen;

  always #5 clk = ~clk;

  intmap_top u_intmap_top (.*);

  // Vector: {line[66:65], enable[64:33], cond aligned to enable bits[32:1], expected[0]}
  localparam int NVEC = 10;
  localparam logic [66:0] VEC [NVEC] = '{
    {2'd0, 32'h8000_0000, 32'h8000_0000, 1'b1},
    {2'd0, 32'h8000_0000, 32'h4000_0000, 1'b0},
    {2'd1, 32'h0001_0000, 32'h0001_0000, 1'b1},
    {2'd2, 32'h0000_8000, 32'h0000_8000, 1'b1},
    {2'd3, 32'h0000_7C00, 32'h0000_0400, 1'b1},
    {2'd3, 32'h0000_3C00, 32'h0000_4000, 1'b0},
    {2'd2, 32'h0000_03FF, 32'hFFFF_FC00, 1'b0},
    {2'd1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    {2'd0, 32'h0C00_0000, 32'h0800_0000, 1'b1},
    {2'd1, 32'h0000_2000, 32'h0000_2000, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bench-side mapping of an enable-aligned condition word onto the ports.
  task automatic set_cond(input logic [31:0] v);
    for (int k = 0; k < 8; k++) begin
      src_out_cond[k] = v[31-2*k];
      src_in_cond[k]  = v[30-2*k];
    end
    bus_cond     = v[15];
    tclk_cond[1] = v[14];
    tclk_cond[0] = v[13];
    ext_cond[2]  = v[12];
    ext_cond[1]  = v[11];
    ext_cond[0]  = v[10];
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    rearm_seen = rearm;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_status(input logic [7:0] ie, input logic [7:0] of,
                                             input logic [7:0] ic, input logic [7:0] oc);
    logic [31:0] s;
    for (int k = 0; k < 8; k++) begin
      s[31-2*k] = oc[k];
      s[30-2*k] = ic[k];
      s[15-2*k] = !of[k];
      s[14-2*k] = !ie[k];
    end
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    // Reset checks (R1, R10)
    src_in_empty = 8'h00; src_out_full = 8'hFF;
    repeat (3) @(negedge clk);
    read_reg(3'd4, rd); check("R10 status during reset", rd, 32'hAAAA_AAAA);
    rst_n = 1'b1;
    #1;
    read_reg(3'd4, rd); check("R10 status after reset", rd, 32'hAAAA_AAAA);
    for (int i = 0; i < 4; i++) begin
      read_reg(3'(i), rd); check("R1 enable reset", rd, 32'h0);
    end
    check("R1 irq reset", {28'h0, irq_line}, 32'h0);
    check("R1 rearm reset", {10'h0, rearm}, 32'h0);
    src_in_empty = 8'hFF; src_out_full = 8'h00;

    // Vector table (R2, R3, R7)
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0]  ln;
      logic [31:0] en, cv;
      logic        ex;
      {ln, en, cv, ex} = VEC[v];
      write_reg({1'b0, ln}, en);
      set_cond(cv);
      @(negedge clk);
      check($sformatf("R2 R3 vector %0d line", v), {31'h0, irq_line[ln]}, {31'h0, ex});
      read_reg({1'b0, ln}, rd);
      check($sformatf("R7 vector %0d readback", v), rd, en & 32'hFFFF_FC00);
    end

    // R12: upper addresses read zero, status write changes nothing
    set_cond(32'h0);
    read_reg(3'd6, rd); check("R12 unused address reads zero", rd, 32'h0);
    read_reg(3'd1, rd);
    write_reg(3'd4, 32'hFFFF_FFFF);
    check("R6 no rearm on status write", {10'h0, rearm_seen}, 32'h0);
    read_reg(3'd1, rd); check("R12 line1 unchanged by status write", rd, 32'h0000_2000);
    write_reg(3'd7, 32'hFFFF_FFFF);
    read_reg(3'd0, rd); check("R12 line0 unchanged by write to 7", rd, 32'h0C00_0000);

    // R5 / R6 rearm
    write_reg(3'd2, 32'hFFFF_FFFF);
    check("R5 rearm all", {10'h0, rearm_seen}, 32'h003F_FFFF);
    write_reg(3'd2, 32'h8000_0400);
    check("R5 rearm already-set bits", {10'h0, rearm_seen}, 32'h0020_0001);
    @(negedge clk);
    check("R6 rearm idle", {10'h0, rearm}, 32'h0);
    write_reg(3'd3, 32'h0000_0000);
    check("R6 rearm on zero write", {10'h0, rearm_seen}, 32'h0);

    // R4: one condition on two lines, two conditions on one line
    write_reg(3'd0, 32'h0000_0800);
    write_reg(3'd3, 32'h0000_0800);
    write_reg(3'd1, 32'h0001_8000);
    write_reg(3'd2, 32'h0);
    set_cond(32'h0000_0800);
    @(negedge clk);
    check("R4 shared condition", {28'h0, irq_line}, 32'h9);
    set_cond(32'h0000_8000);
    @(negedge clk);
    check("R4 second of two on line1", {28'h0, irq_line}, 32'h2);

    // R11: write clearing an enable while its condition is held
    write_reg(3'd1, 32'h0);
    write_reg(3'd0, 32'h8000_0000);
    set_cond(32'h8000_0000);
    @(negedge clk);
    check("R11 line up before write", {31'h0, irq_line[0]}, 32'h1);
    write_reg(3'd0, 32'h0);
    check("R11 line still up at write edge", {31'h0, irq_line[0]}, 32'h1);
    check("R11 no rearm with zero write", {10'h0, rearm_seen}, 32'h0);
    @(negedge clk);
    check("R11 line down one edge later", {31'h0, irq_line[0]}, 32'h0);
    write_reg(3'd0, 32'h8000_0000);
    write_reg(3'd0, 32'h8000_0000);
    check("R5 rearm on rewrite", {10'h0, rearm_seen}, 32'h0020_0000);
    check("R11 line steady on rewrite", {31'h0, irq_line[0]}, 32'h1);
    set_cond(32'h0);

    // R8 / R9 status packing
    @(negedge clk);
    src_in_empty = 8'b1010_0110; src_out_full = 8'b0011_1001;
    src_in_cond  = 8'b1100_0101; src_out_cond = 8'b0110_1010;
    @(negedge clk);
    read_reg(3'd4, rd);
    check("R8 R9 status pattern A", rd, exp_status(8'b1010_0110, 8'b0011_1001, 8'b1100_0101, 8'b0110_1010));
    src_in_empty = 8'h00; src_out_full = 8'hFF; src_in_cond = 8'hFF; src_out_cond = 8'h00;
    @(negedge clk);
    read_reg(3'd4, rd);
    check("R8 R9 status pattern B", rd, 32'h5555_5555);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule